// File: doc/BRIEF.md
# Microcode Sequencer with Jump-Type Control

This block is the control unit of a bus-based processor that runs every instruction as a short microprogram. It holds a 64-word microcode ROM and a 6-bit micro-program counter (micro-PC). Each ROM word has three parts: 17 control lines that drive the datapath, a 3-bit jump type, and a 6-bit absolute target. The control lines of the word at the current micro-PC go straight to the `ctrl` port. The next micro-PC is picked from four candidates: the micro-PC plus one, the current micro-PC, the absolute target, or the entry address of the routine for the opcode's instruction group. The jump type and the `zero` and `busy` status inputs decide which one is used.

The ROM holds the instruction-fetch sequence and one routine for each instruction group: register ALU, immediate ALU, load, store, branch-if-zero, branch-if-nonzero, jump, jump-register, jump-and-link, jump-and-link-register, and a memory-to-memory ALU operation. The datapath supplies `opcode` from its instruction register, `zero` from its A register and `busy` from the memory. The register file, the ALU and the memory are outside this block.

Top module: `ucode_seq`

## Requirements
- R1: After reset the micro-PC is 0, the fetch entry. `ctrl` then equals 0x00621: load address register (bit 0), register drives bus (bit 5), register select PC (value 3 in bits 11:9).
- R2: Jump type next (code 0) moves the micro-PC to micro-PC+1.
- R3: Jump type spin (code 1) holds the micro-PC while `busy` is 1 and moves to micro-PC+1 in the first cycle that `busy` is 0.
- R4: Jump type fetch (code 2), and the unused codes 6 and 7, return the micro-PC to 0.
- R5: Jump type dispatch (code 3) loads the group entry address. The entries are: opcode 0x00 → 4; 0x08..0x0F → 7; 0x23 → 10; 0x2B → 15; 0x04 → 20; 0x05 → 25; 0x02 → 30; 0x06 → 33; 0x03 → 35; 0x07 → 39; 0x30 → 43.
- R6: Jump type feqz (code 4) jumps to the absolute target when `zero` is 1 and moves to micro-PC+1 otherwise. Branch-if-nonzero (entry 25) with `zero`=1 goes back to 0 from step 26.
- R7: Jump type fnez (code 5) moves to micro-PC+1 when `zero` is 1 and jumps to the target otherwise. Branch-if-zero (entry 20) with `zero`=0 goes back to 0 from step 21.
- R8: Fetch runs at micro-PC 0,1,2,3 and spins at 1 on memory. Step 1 drives 0x00042 (instruction register load, memory enable in bit 6). Step 3 drives 0x04610: register write (bit 4), select PC, ALU op A+4 (value 4 in bits 14:12). It then dispatches.
- R9: The load routine visits 10,11,12,13,14 and spins at 13. Step 13 drives 0x00250: register write, memory enable, select rt (value 1). Step 14 returns to fetch.
- R10: A taken branch-if-zero (`zero`=1) visits 20..24. Step 23 drives 0x10108: B load (bit 3), immediate enable (bit 8), shifted sign-extension (value 2 in bits 16:15). Step 24 drives 0x03610: PC written with A+B (ALU op 3).
- R11: Jump-and-link writes the link register (select 4, ALU pass A = op 1, ctrl 0x01810) at step 36. The PC is written with the jump target (ALU op 6, ctrl 0x06610) later, at step 38.
- R12: The memory-to-memory ALU routine (43..49) makes exactly three memory accesses, at steps 44, 46 and 48, each spinning on `busy`. Only the last one sets memory write (bit 7), with ctrl 0x050C0 (ALU op 5).
- R13: An opcode outside the listed groups dispatches to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode from the instruction register |
| zero | input | 1 | A register is zero |
| busy | input | 1 | Memory access in progress |
| ctrl | output | 17 | Datapath control lines of the current micro-instruction |
| upc | output | 6 | Current micro-PC |

## Verification
The hardest case to reach is a spin step that comes deep inside a routine. In the memory-to-memory routine, three separate spins must each hold for several cycles, and nothing else in the routine may move. To reach it, the bench drives the opcode through a full fetch and dispatch. It then raises `busy` on the exact cycle the micro-PC lands on each access step, and drops it a chosen number of cycles later. Both branch polarities are run with each value of `zero`, so that the jump to the absolute target and the fall-through are both seen.

// File: rtl/ucode_seq.sv
module ucode_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  opcode,
  input  logic        zero,
  input  logic        busy,
  output logic [16:0] ctrl,
  output logic [5:0]  upc
);

  localparam logic [2:0] J_NEXT  = 3'd0;
  localparam logic [2:0] J_SPIN  = 3'd1;
  localparam logic [2:0] J_FETCH = 3'd2;
  localparam logic [2:0] J_DISP  = 3'd3;
  localparam logic [2:0] J_FEQZ  = 3'd4;
  localparam logic [2:0] J_FNEZ  = 3'd5;

  localparam logic [16:0] C_LDMA = 17'h00001;
  localparam logic [16:0] C_LDIR = 17'h00002;
  localparam logic [16:0] C_LDA  = 17'h00004;
  localparam logic [16:0] C_LDB  = 17'h00008;
  localparam logic [16:0] C_RWR  = 17'h00010;
  localparam logic [16:0] C_REN  = 17'h00020;
  localparam logic [16:0] C_MEN  = 17'h00040;
  localparam logic [16:0] C_MWR  = 17'h00080;
  localparam logic [16:0] C_IEN  = 17'h00100;
  localparam logic [16:0] RS_RS  = 17'h00000;
  localparam logic [16:0] RS_RT  = 17'h00200;
  localparam logic [16:0] RS_RD  = 17'h00400;
  localparam logic [16:0] RS_PC  = 17'h00600;
  localparam logic [16:0] RS_LNK = 17'h00800;
  localparam logic [16:0] OP_PA  = 17'h01000;
  localparam logic [16:0] OP_PB  = 17'h02000;
  localparam logic [16:0] OP_ADD = 17'h03000;
  localparam logic [16:0] OP_A4  = 17'h04000;
  localparam logic [16:0] OP_FN  = 17'h05000;
  localparam logic [16:0] OP_JT  = 17'h06000;
  localparam logic [16:0] EX_S16 = 17'h00000;
  localparam logic [16:0] EX_S2  = 17'h10000;
  localparam logic [16:0] EX_IR  = 17'h18000;

  localparam logic [5:0] A_FETCH = 6'd0;
  localparam logic [5:0] A_ALU   = 6'd4;
  localparam logic [5:0] A_ALUI  = 6'd7;
  localparam logic [5:0] A_LW    = 6'd10;
  localparam logic [5:0] A_SW    = 6'd15;
  localparam logic [5:0] A_BEQZ  = 6'd20;
  localparam logic [5:0] A_BNEZ  = 6'd25;
  localparam logic [5:0] A_J     = 6'd30;
  localparam logic [5:0] A_JR    = 6'd33;
  localparam logic [5:0] A_JAL   = 6'd35;
  localparam logic [5:0] A_JALR  = 6'd39;
  localparam logic [5:0] A_MM    = 6'd43;

  function automatic logic [25:0] uw(input logic [16:0] c, input logic [2:0] j,
                                     input logic [5:0] t);
    return {t, j, c};
  endfunction

  function automatic logic [25:0] rom(input logic [5:0] a);
    case (a)
      6'd0:  return uw(C_LDMA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd1:  return uw(C_LDIR | C_MEN, J_SPIN, A_FETCH);
      6'd2:  return uw(C_LDA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd3:  return uw(C_RWR | RS_PC | OP_A4, J_DISP, A_FETCH);
      6'd4:  return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd5:  return uw(C_LDB | C_REN | RS_RT, J_NEXT, A_FETCH);
      6'd6:  return uw(C_RWR | RS_RD | OP_FN, J_FETCH, A_FETCH);
      6'd7:  return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd8:  return uw(C_LDB | C_IEN | EX_S16, J_NEXT, A_FETCH);
      6'd9:  return uw(C_RWR | RS_RT | OP_FN, J_FETCH, A_FETCH);
      6'd10: return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd11: return uw(C_LDB | C_IEN | EX_S16, J_NEXT, A_FETCH);
      6'd12: return uw(C_LDMA | OP_ADD, J_NEXT, A_FETCH);
      6'd13: return uw(C_RWR | C_MEN | RS_RT, J_SPIN, A_FETCH);
      6'd14: return uw(17'd0, J_FETCH, A_FETCH);
      6'd15: return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd16: return uw(C_LDB | C_IEN | EX_S16, J_NEXT, A_FETCH);
      6'd17: return uw(C_LDMA | OP_ADD, J_NEXT, A_FETCH);
      6'd18: return uw(C_MEN | C_MWR | C_REN | RS_RT, J_SPIN, A_FETCH);
      6'd19: return uw(17'd0, J_FETCH, A_FETCH);
      6'd20: return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd21: return uw(17'd0, J_FNEZ, A_FETCH);
      6'd22: return uw(C_LDA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd23: return uw(C_LDB | C_IEN | EX_S2, J_NEXT, A_FETCH);
      6'd24: return uw(C_RWR | RS_PC | OP_ADD, J_FETCH, A_FETCH);
      6'd25: return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd26: return uw(17'd0, J_FEQZ, A_FETCH);
      6'd27: return uw(C_LDA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd28: return uw(C_LDB | C_IEN | EX_S2, J_NEXT, A_FETCH);
      6'd29: return uw(C_RWR | RS_PC | OP_ADD, J_FETCH, A_FETCH);
      6'd30: return uw(C_LDA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd31: return uw(C_LDB | C_IEN | EX_IR, J_NEXT, A_FETCH);
      6'd32: return uw(C_RWR | RS_PC | OP_JT, J_FETCH, A_FETCH);
      6'd33: return uw(C_LDA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd34: return uw(C_RWR | RS_PC | OP_PA, J_FETCH, A_FETCH);
      6'd35: return uw(C_LDA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd36: return uw(C_RWR | RS_LNK | OP_PA, J_NEXT, A_FETCH);
      6'd37: return uw(C_LDB | C_IEN | EX_IR, J_NEXT, A_FETCH);
      6'd38: return uw(C_RWR | RS_PC | OP_JT, J_FETCH, A_FETCH);
      6'd39: return uw(C_LDA | C_REN | RS_PC, J_NEXT, A_FETCH);
      6'd40: return uw(C_LDB | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd41: return uw(C_RWR | RS_LNK | OP_PA, J_NEXT, A_FETCH);
      6'd42: return uw(C_RWR | RS_PC | OP_PB, J_FETCH, A_FETCH);
      6'd43: return uw(C_LDMA | C_REN | RS_RS, J_NEXT, A_FETCH);
      6'd44: return uw(C_LDA | C_MEN, J_SPIN, A_FETCH);
      6'd45: return uw(C_LDMA | C_REN | RS_RT, J_NEXT, A_FETCH);
      6'd46: return uw(C_LDB | C_MEN, J_SPIN, A_FETCH);
      6'd47: return uw(C_LDMA | C_REN | RS_RD, J_NEXT, A_FETCH);
      6'd48: return uw(C_MEN | C_MWR | OP_FN, J_SPIN, A_FETCH);
      6'd49: return uw(17'd0, J_FETCH, A_FETCH);
      default: return uw(17'd0, J_FETCH, A_FETCH);
    endcase
  endfunction

  logic [25:0] word;
  logic [2:0]  jt;
  logic [5:0]  tgt, disp, inc, nxt;

  assign word = rom(upc);
  assign ctrl = word[16:0];
  assign jt   = word[19:17];
  assign tgt  = word[25:20];
  assign inc  = upc + 6'd1;

  always_comb begin
    case (opcode)
      6'h00:                 disp = A_ALU;
      6'h08, 6'h09, 6'h0A, 6'h0B,
      6'h0C, 6'h0D, 6'h0E, 6'h0F: disp = A_ALUI;
      6'h23:                 disp = A_LW;
      6'h2B:                 disp = A_SW;
      6'h04:                 disp = A_BEQZ;
      6'h05:                 disp = A_BNEZ;
      6'h02:                 disp = A_J;
      6'h06:                 disp = A_JR;
      6'h03:                 disp = A_JAL;
      6'h07:                 disp = A_JALR;
      6'h30:                 disp = A_MM;
      default:               disp = A_FETCH;
    endcase
  end

  always_comb begin
    case (jt)
      J_NEXT:  nxt = inc;
      J_SPIN:  nxt = busy ? upc : inc;
      J_DISP:  nxt = disp;
      J_FEQZ:  nxt = zero ? tgt : inc;
      J_FNEZ:  nxt = zero ? inc : tgt;
      default: nxt = A_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) upc <= A_FETCH;
    else        upc <= nxt;

  p_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jt == J_NEXT |=> upc == $past(upc) + 6'd1);
  p_spin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_SPIN && busy) |=> $stable(upc));
  p_spin_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_SPIN && !busy) |=> upc == $past(upc) + 6'd1);
  p_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_FETCH || jt > J_FNEZ) |=> upc == 6'd0);
  p_disp_lw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_DISP && opcode == 6'h23) |=> upc == 6'd10);
  p_feqz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_FEQZ && !zero) |=> upc == $past(upc) + 6'd1);
  p_fnez_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_FNEZ && zero) |=> upc == $past(upc) + 6'd1);
  p_wr_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |-> ctrl[6]);

endmodule

// File: tb/ucode_seq_tb.sv
module ucode_seq_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, zero = 0, busy = 0;
  logic [5:0] opcode = 6'h00;
  logic [16:0] ctrl;
  logic [5:0] upc;
  int errs = 0, nchk = 0;

  ucode_seq dut_i (.clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
                   .busy(busy), .ctrl(ctrl), .upc(upc));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic st(input int e, input logic b, input string req);
    chk(upc, e, req);
    busy = b;
    @(negedge clk);
  endtask

  task automatic do_fetch(input logic [5:0] op, input string req);
    opcode = op;
    st(0, 0, req); st(1, 0, req); st(2, 0, req); st(3, 0, req);
  endtask

  task automatic t_reset;
    chk(upc, 0, "R1 reset upc");
    chk(ctrl, 17'h00621, "R1 reset ctrl");
  endtask

  task automatic t_fetch_alu;
    opcode = 6'h00;
    st(0, 0, "R8"); chk(ctrl, 17'h00042, "R8 step1 ctrl");
    st(1, 0, "R2 next"); st(2, 0, "R8");
    chk(ctrl, 17'h04610, "R8 step3 ctrl");
    st(3, 0, "R8"); st(4, 0, "R5 alu dispatch"); st(5, 0, "R2"); st(6, 0, "R2");
    chk(upc, 0, "R4 fetch return");
  endtask

  task automatic t_spin;
    opcode = 6'h08;
    st(0, 0, "R3");
    st(1, 1, "R3 hold"); st(1, 1, "R3 hold"); st(1, 1, "R3 hold");
    st(1, 0, "R3 hold"); st(2, 0, "R3 release");
    st(3, 0, "R8"); st(7, 0, "R5 alui dispatch"); st(8, 0, "R2"); st(9, 0, "R2");
    chk(upc, 0, "R4");
  endtask

  task automatic t_lw;
    do_fetch(6'h23, "R9");
    st(10, 0, "R5 load dispatch"); st(11, 0, "R9"); st(12, 0, "R9");
    chk(ctrl, 17'h00250, "R9 step13 ctrl");
    st(13, 1, "R9"); st(13, 1, "R9 spin"); st(13, 0, "R9 spin");
    st(14, 0, "R9 after spin");
    chk(upc, 0, "R4 load end");
  endtask

  task automatic t_beqz(input logic z);
    zero = z;
    do_fetch(6'h04, "R10");
    st(20, 0, "R5 beqz dispatch"); st(21, 0, "R7");
    if (z) begin
      st(22, 0, "R7 fall through"); chk(ctrl, 17'h10108, "R10 step23 ctrl");
      st(23, 0, "R10"); chk(ctrl, 17'h03610, "R10 step24 ctrl");
      st(24, 0, "R10");
    end
    chk(upc, 0, z ? "R10 end" : "R7 jump to target");
    zero = 0;
  endtask

  task automatic t_bnez(input logic z);
    zero = z;
    do_fetch(6'h05, "R6");
    st(25, 0, "R5 bnez dispatch"); st(26, 0, "R6");
    if (!z) begin
      st(27, 0, "R6 fall through"); st(28, 0, "R6"); st(29, 0, "R6");
    end
    chk(upc, 0, z ? "R6 jump to target" : "R6 end");
    zero = 0;
  endtask

  task automatic t_jal;
    int link_at = -1, pc_at = -1;
    do_fetch(6'h03, "R11");
    for (int i = 0; i < 4; i++) begin
      if (ctrl == 17'h01810) link_at = upc;
      if (ctrl == 17'h06610) pc_at = upc;
      st(35 + i, 0, "R11 path");
    end
    chk(link_at, 36, "R11 link write step");
    chk(pc_at, 38, "R11 pc write step");
    chk(upc, 0, "R11 end");
  endtask

  task automatic t_mm;
    int accesses = 0, writes = 0;
    do_fetch(6'h30, "R12");
    st(43, 0, "R5 mm dispatch");
    for (int k = 0; k < 3; k++) begin
      int s = 44 + 2 * k;
      if (ctrl[6]) accesses++;
      if (ctrl[7]) writes++;
      if (k == 2) chk(ctrl, 17'h050C0, "R12 write ctrl");
      st(s, 1, "R12"); st(s, 1, "R12 spin"); st(s, 0, "R12 spin");
      if (k < 2) begin
        if (ctrl[6]) accesses++;
        st(s + 1, 0, "R12");
      end
    end
    st(49, 0, "R12 tail");
    chk(accesses, 3, "R12 access count");
    chk(writes, 1, "R12 write count");
    chk(upc, 0, "R12 end");
  endtask

  task automatic t_illegal;
    do_fetch(6'h3F, "R13");
    chk(upc, 0, "R13 unknown opcode");
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fetch_alu();
    t_spin();
    t_lw();
    t_beqz(1);
    t_beqz(0);
    t_bnez(1);
    t_bnez(0);
    t_jal();
    t_mm();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule